// File: doc/BRIEF.md
# Conditional Flow and Loop Controller

This block sequences the program counter of a small DSP core. In each cycle it receives the operation that the decoder found at the current PC, plus a 4-bit condition field and a condition verdict that are computed elsewhere. From these it selects the next PC. It covers the following cases:

- straight-line advance;
- conditional jump, call and return;
- skip-next-instruction;
- interrupt entry and return from interrupt;
- halt;
- zero-overhead block loops.

Condition evaluation, the ALU and memory live outside the block.

Four small LIFO stacks hold the flow state:

- **return addresses**, which are shared by calls and loop starts;
- **saved status words**;
- **loop end addresses**;
- **loop counts**.

When the PC reaches the end address on top of the loop-end stack, the controller handles the loop without any extra instruction. It either branches back to the loop start or drops all three loop entries and falls through.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the PC is 0, halted is 0, every overflow and underflow flag is 0 and loop_depth is 0. With no redirect, the PC advances by 2 when two_word is 1 and by 1 otherwise.
- R2: A condition counts as true when cond is 4'hF, and otherwise follows cond_ok. A jump (op 1) with a true condition loads target into the PC; with a false condition it advances normally.
- R3: A call (op 2) with a true condition pushes the address of the following instruction on the return stack and loads target. A return (op 3) with a true condition pops the return stack into the PC. With a false condition, either one only advances the PC.
- R4: A skip (op 5) with a false condition sets the PC to the following address plus the size of the next instruction (2 when next_two is 1, else 1). With a true condition it advances normally.
- R5: Interrupt entry (op 8) pushes the following address on the return stack and status_in on the status stack, then loads target. Return from interrupt (op 4) ignores the condition. It pops the status stack into sr_out, pulses sr_load for one cycle, and pops the return stack into the PC.
- R6: A block loop (op 7) with a nonzero count pushes the following address (the loop start) on the return stack, target on the loop-end stack and count on the loop-count stack, and advances the PC.
- R7: A block loop with count 0 pushes nothing and sets the PC to target plus the size of the instruction at target (next_two).
- R8: In a non-redirecting cycle with at least one active loop and PC equal to the top loop-end address, one of two things happens. If the top count is greater than 1, the count is decremented (visible on loop_count) and the PC reloads from the return-stack top. Otherwise the PC advances and one entry is popped from each of the three loop stacks.
- R9: Halt (op 6) freezes the PC and sets halted (bit 2 of the control word). Both stay until reset, and every later operation is ignored.
- R10: Each stack holds DEPTH entries. A push onto a full stack is dropped and sets a sticky ovf bit. A pop from an empty stack sets a sticky unf bit and yields 0. The bit order is: 0 return, 1 status, 2 loop-end, 3 loop-count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Decoded operation: 0 seq, 1 jump, 2 call, 3 return, 4 return-from-interrupt, 5 skip, 6 halt, 7 block loop, 8 interrupt entry |
| cond | input | 4 | Condition field from the opcode's low nibble; 4'hF means always |
| cond_ok | input | 1 | Verdict of the external condition evaluator |
| two_word | input | 1 | Current instruction is two words long |
| next_two | input | 1 | Instruction after the current one (or at the loop end) is two words long |
| target | input | W | Fetched target word / loop end address / vector |
| count | input | W | Block loop count |
| status_in | input | W | Status word saved on interrupt entry |
| pc | output | W | Program counter |
| halted | output | 1 | Halt state (control bit 2) |
| sr_out | output | W | Status word restored by return from interrupt |
| sr_load | output | 1 | One-cycle strobe when sr_out is refreshed |
| loop_count | output | W | Count on top of the loop-count stack |
| loop_depth | output | $clog2(DEPTH+1) | Number of active loops |
| ovf | output | 4 | Sticky overflow flags per stack |
| unf | output | 4 | Sticky underflow flags per stack |

## Verification
The bench builds the block with W=16 and DEPTH=4. With the shallow stack, five nested calls are enough to hit the overflow drop, and five returns are enough to underflow. A single return from interrupt on fresh stacks underflows two stacks at once. A 16-bit PC keeps all the table addresses small, and it still lets the loop-end compare run against the same registers that the return path uses.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int W = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 op,
  input  logic [3:0]                 cond,
  input  logic                       cond_ok,
  input  logic                       two_word,
  input  logic                       next_two,
  input  logic [W-1:0]               target,
  input  logic [W-1:0]               count,
  input  logic [W-1:0]               status_in,
  output logic [W-1:0]               pc,
  output logic                       halted,
  output logic [W-1:0]               sr_out,
  output logic                       sr_load,
  output logic [W-1:0]               loop_count,
  output logic [$clog2(DEPTH+1)-1:0] loop_depth,
  output logic [3:0]                 ovf,
  output logic [3:0]                 unf
);
  localparam int PW = $clog2(DEPTH+1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CS = 0, DS = 1, LA = 2, LC = 3;
  localparam logic [3:0] OP_JMP = 4'd1, OP_CALL = 4'd2, OP_RET = 4'd3, OP_RTI = 4'd4,
                         OP_SKIP = 4'd5, OP_HALT = 4'd6, OP_LOOP = 4'd7, OP_INTR = 4'd8;

  logic [3:0]   push, pop;
  logic [W-1:0] pdat [4];
  logic [W-1:0] top  [4];
  logic [W-1:0] nxt;
  logic         dec_lc, halt_set, rti_go, alt;

  wire          taken   = (cond == 4'hF) | cond_ok;
  wire [W-1:0]  pc_inc  = pc + (two_word ? W'(2) : W'(1));
  wire [W-1:0]  nxt_len = next_two ? W'(2) : W'(1);

  always_comb begin
    push = '0; pop = '0; dec_lc = 1'b0; halt_set = 1'b0; rti_go = 1'b0; alt = 1'b0;
    nxt = pc_inc;
    pdat[CS] = pc_inc; pdat[DS] = status_in; pdat[LA] = target; pdat[LC] = count;
    if (halted) begin
      nxt = pc;
    end else begin
      case (op)
        OP_JMP:  if (taken) begin nxt = target; alt = 1'b1; end
        OP_CALL: if (taken) begin push[CS] = 1'b1; nxt = target; alt = 1'b1; end
        OP_RET:  if (taken) begin pop[CS] = 1'b1; nxt = top[CS]; alt = 1'b1; end
        OP_RTI:  begin pop[CS] = 1'b1; pop[DS] = 1'b1; rti_go = 1'b1; nxt = top[CS]; alt = 1'b1; end
        OP_SKIP: if (!taken) begin nxt = pc_inc + nxt_len; alt = 1'b1; end
        OP_HALT: begin halt_set = 1'b1; nxt = pc; alt = 1'b1; end
        OP_LOOP: begin
          alt = 1'b1;
          if (count != '0) begin
            push[CS] = 1'b1; push[LA] = 1'b1; push[LC] = 1'b1;
          end else begin
            nxt = target + nxt_len;
          end
        end
        OP_INTR: begin push[CS] = 1'b1; push[DS] = 1'b1; nxt = target; alt = 1'b1; end
        default: ;
      endcase
      if (!alt && loop_depth != '0 && pc == top[LA]) begin
        if (top[LC] > W'(1)) begin
          dec_lc = 1'b1;
          nxt = top[CS];
        end else begin
          pop[CS] = 1'b1; pop[LA] = 1'b1; pop[LC] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_stk
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] sp;
    logic          of, uf;
    wire  [IW-1:0] wr_i  = IW'(sp);
    wire  [IW-1:0] top_i = IW'(sp - 1'b1);

    assign top[g] = (sp == '0) ? '0 : mem[top_i];
    assign ovf[g] = of;
    assign unf[g] = uf;
    if (g == LA) begin : g_dep
      assign loop_depth = sp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sp <= '0; of <= 1'b0; uf <= 1'b0;
      end else if (push[g]) begin
        if (sp == PW'(DEPTH)) of <= 1'b1;
        else sp <= sp + 1'b1;
      end else if (pop[g]) begin
        if (sp == '0) uf <= 1'b1;
        else sp <= sp - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst_n && push[g] && sp != PW'(DEPTH)) mem[wr_i] <= pdat[g];
      else if (rst_n && g == LC && dec_lc && !pop[g]) mem[top_i] <= top[g] - 1'b1;
    end
  end

  assign loop_count = top[LC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; halted <= 1'b0; sr_out <= '0; sr_load <= 1'b0;
    end else begin
      pc <= nxt;
      if (halt_set) halted <= 1'b1;
      sr_load <= rti_go;
      if (rti_go) sr_out <= top[DS];
    end
  end
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int W = 16,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [3:0]                 op,
  input logic [3:0]                 cond,
  input logic                       cond_ok,
  input logic                       next_two,
  input logic [W-1:0]               target,
  input logic [W-1:0]               count,
  input logic [W-1:0]               pc,
  input logic                       halted,
  input logic                       sr_load,
  input logic [$clog2(DEPTH+1)-1:0] loop_depth,
  input logic [3:0]                 ovf,
  input logic [3:0]                 unf
);
  localparam int PW = $clog2(DEPTH+1);

  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc)));

  p_call_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && op == 4'd2 && (cond == 4'hF || cond_ok)) |=> (pc == $past(target)));

  p_jump_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && op == 4'd1 && cond == 4'hF) |=> (pc == $past(target)));

  p_rti_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && op == 4'd4) |=> sr_load);

  p_zero_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && op == 4'd7 && count == '0) |=> (pc == $past(target) + W'($past(next_two) ? 2 : 1)));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf != 4'd0) |=> ((ovf & $past(ovf)) == $past(ovf)));

  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (unf != 4'd0) |=> ((unf & $past(unf)) == $past(unf)));

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loop_depth <= PW'(DEPTH));
endmodule

bind pc_sequencer pc_sequencer_chk #(.W(W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  localparam int W = 16;
  localparam int DEPTH = 4;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = '0, cond = '0;
  logic cond_ok = 1'b0, two_word = 1'b0, next_two = 1'b0;
  logic [W-1:0] target = '0, count = '0, status_in = '0;
  logic [W-1:0] pc, sr_out, loop_count;
  logic halted, sr_load;
  logic [$clog2(DEPTH+1)-1:0] loop_depth;
  logic [3:0] ovf, unf;

  always #5 clk = ~clk;

  pc_sequencer #(.W(W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .op(op), .cond(cond), .cond_ok(cond_ok),
    .two_word(two_word), .next_two(next_two), .target(target), .count(count),
    .status_in(status_in), .pc(pc), .halted(halted), .sr_out(sr_out),
    .sr_load(sr_load), .loop_count(loop_count), .loop_depth(loop_depth),
    .ovf(ovf), .unf(unf));

  // {op, cond, cond_ok, two_word, next_two, target, count, expected pc}
  localparam logic [58:0] VEC [NV] = '{
    {4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0001},
    {4'd0, 4'h0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'd0, 16'h0003},
    {4'd1, 4'h0, 1'b0, 1'b1, 1'b0, 16'h0040, 16'd0, 16'h0005},
    {4'd1, 4'h0, 1'b1, 1'b1, 1'b0, 16'h0040, 16'd0, 16'h0040},
    {4'd1, 4'hF, 1'b0, 1'b1, 1'b0, 16'h0050, 16'd0, 16'h0050},
    {4'd2, 4'hF, 1'b0, 1'b1, 1'b0, 16'h0100, 16'd0, 16'h0100},
    {4'd2, 4'h2, 1'b0, 1'b1, 1'b0, 16'h0200, 16'd0, 16'h0102},
    {4'd3, 4'h3, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0103},
    {4'd3, 4'hF, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0052},
    {4'd5, 4'hF, 1'b0, 1'b0, 1'b1, 16'h0000, 16'd0, 16'h0053},
    {4'd5, 4'h1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'd0, 16'h0056},
    {4'd5, 4'h1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0058},
    {4'd7, 4'h0, 1'b0, 1'b1, 1'b1, 16'h0070, 16'd0, 16'h0072},
    {4'd7, 4'h0, 1'b0, 1'b1, 1'b0, 16'h0075, 16'd3, 16'h0074},
    {4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0075},
    {4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0074},
    {4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0075},
    {4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0074},
    {4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0075},
    {4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0076}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] o, input logic [3:0] c, input logic ok,
                     input logic tw, input logic nt, input logic [W-1:0] t,
                     input logic [W-1:0] cnt, input logic [W-1:0] st);
    op = o; cond = c; cond_ok = ok; two_word = tw; next_two = nt;
    target = t; count = cnt; status_in = st;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op = '0; cond = '0; cond_ok = 1'b0; two_word = 1'b0; next_two = 1'b0;
    target = '0; count = '0; status_in = '0;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [58:0] v;
    string tag;
    do_reset();
    chk("R1 reset pc", pc, 0);
    chk("R1 reset halted", halted, 0);
    chk("R1 reset flags", {ovf, unf}, 0);
    chk("R1 reset loop_depth", loop_depth, 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      case (v[58:55])
        4'd0: tag = (i >= 14) ? "R8 loop end" : "R1 advance";
        4'd1: tag = "R2 jump";
        4'd2, 4'd3: tag = "R3 call/return";
        4'd5: tag = "R4 skip";
        default: tag = (v[31:16] == 0) ? "R7 zero loop" : "R6 loop start";
      endcase
      cyc(v[58:55], v[54:51], v[50], v[49], v[48], v[47:32], v[31:16], 16'h0);
      chk(tag, pc, v[15:0]);
      if (i == 13) begin
        chk("R6 loop_depth", loop_depth, 1);
        chk("R6 loop_count", loop_count, 3);
      end
    end
    chk("R8 loops popped", loop_depth, 0);

    cyc(4'd8, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0200, 16'd0, 16'hABCD);
    chk("R5 interrupt entry pc", pc, 16'h0200);
    cyc(4'd4, 4'h3, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0000);
    chk("R5 rti pc", pc, 16'h0077);
    chk("R5 rti sr_out", sr_out, 16'hABCD);
    chk("R5 rti sr_load", sr_load, 1);
    cyc(4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0000);
    chk("R5 sr_load one cycle", sr_load, 0);

    do_reset();
    for (int k = 1; k <= 4; k++) begin
      cyc(4'd2, 4'hF, 1'b0, 1'b0, 1'b0, W'(k * 16), 16'd0, 16'h0);
    end
    chk("R10 no overflow at depth", ovf, 0);
    cyc(4'd2, 4'hF, 1'b0, 1'b0, 1'b0, 16'h0050, 16'd0, 16'h0);
    chk("R10 call overflow flag", ovf, 4'b0001);
    chk("R10 call after full loads target", pc, 16'h0050);
    for (int k = 1; k <= 4; k++) begin
      cyc(4'd3, 4'hF, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0);
      chk("R3 nested return", pc, W'((4 - k) * 16 + 1));
    end
    chk("R10 no underflow yet", unf, 0);
    cyc(4'd3, 4'hF, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0);
    chk("R10 return underflow flag", unf, 4'b0001);
    chk("R10 empty pop yields zero", pc, 0);
    cyc(4'd4, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0);
    chk("R10 rti underflows two stacks", unf, 4'b0011);
    chk("R10 overflow flag sticky", ovf, 4'b0001);

    do_reset();
    cyc(4'd7, 4'h0, 1'b0, 1'b1, 1'b0, 16'h0005, 16'd2, 16'h0);
    chk("R6 loop start pc", pc, 2);
    cyc(4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0);
    cyc(4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0);
    cyc(4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0);
    chk("R8 reach end", pc, 5);
    cyc(4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0);
    chk("R8 branch back", pc, 2);
    chk("R8 count decremented", loop_count, 1);

    do_reset();
    cyc(4'd0, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0);
    cyc(4'd6, 4'h0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd0, 16'h0);
    chk("R9 halt holds pc", pc, 1);
    chk("R9 halted set", halted, 1);
    cyc(4'd1, 4'hF, 1'b0, 1'b0, 1'b0, 16'h0099, 16'd0, 16'h0);
    chk("R9 jump ignored while halted", pc, 1);
    cyc(4'd2, 4'hF, 1'b0, 1'b0, 1'b0, 16'h0033, 16'd0, 16'h0);
    chk("R9 call ignored while halted", pc, 1);
    chk("R9 still halted", halted, 1);
    do_reset();
    chk("R1 reset clears halt", halted, 0);
    chk("R1 reset pc after halt", pc, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule